// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block follows a scatter-gather list held in memory and turns it into a stream of buffer records for a downstream data fetcher. A list is a run of 8-byte descriptors. Each descriptor holds two 32-bit words. The word at offset 0 carries the buffer length and an end-of-list flag. The word at offset 4 carries the buffer address. Descriptor `i` lives at `base + 8*i`.

A single start pulse hands the walker a base address. The walker then issues one word read at a time on a simple request/response memory port. It decodes each descriptor into an (address, length, last) record and offers that record on a valid/ready stream. The walk ends in one of two ways. Normally it ends at the descriptor whose end flag is set. If no flag appears, a hard entry limit stops the walk, marks the final record as last and raises an error flag. Fetching the buffer contents is left to the consumer of the record stream.

When the walk finishes, a one-cycle done pulse is raised. The number of records delivered is reported and held until the next walk begins.

Top module: `sg_list_walker`

## Requirements
- R1: After reset the walker is idle. `busy_o`, `done_o`, `err_o`, `rd_req_valid_o` and `desc_valid_o` are 0, and `count_o` is 0.
- R2: A `start_i` pulse while idle captures `base_addr_i`. One cycle later `busy_o` is 1 and the first read request is presented at the captured base address.
- R3: For descriptor `i`, the length word is read at `base + 8*i` and then the address word at `base + 8*i + 4`. These are two separate requests, each held stable until `rd_req_ready_i`, with only one request outstanding at a time. No record is offered while a request is pending.
- R4: A record's length is bits 27:0 of the length word. A record's address is the address word with bit 31 cleared. Bits 30:28 of the length word never reach the record.
- R5: The walk ends with the record whose length word has bit 31 set. That record has `desc_last_o` = 1 and every earlier record has `desc_last_o` = 0.
- R6: If `MAX_ENTRIES` records pass without bit 31 set, the walk stops after the last of them. That record carries `desc_last_o` = 1 and `err_o` is 1 once the walk ends. If the marker is present, even on entry `MAX_ENTRIES`, `err_o` is 0. `count_o` never exceeds `MAX_ENTRIES`.
- R7: While `desc_valid_o` is 1 and `desc_ready_i` is 0, the record and its valid stay unchanged.
- R8: `done_o` is a single-cycle pulse in the cycle after the final record is accepted. At that point `count_o` equals the number of records delivered, and it keeps that value, along with `err_o`, until the next accepted start.
- R9: `start_i` has no effect while `busy_o` is 1, including the cycle in which `done_o` is high. The walk in progress keeps its base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| base_addr_i | input | ADDR_W | Byte address of descriptor 0 |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| err_o | output | 1 | Last walk hit the entry limit without a marker |
| count_o | output | CNT_W | Records delivered in the current or last walk |
| rd_req_valid_o | output | 1 | Memory read request valid |
| rd_req_ready_i | input | 1 | Memory accepts the request |
| rd_req_addr_o | output | ADDR_W | Byte address of the 32-bit word to read |
| rd_rsp_valid_i | input | 1 | Read data valid |
| rd_rsp_data_i | input | 32 | Read word, little-endian value |
| desc_valid_o | output | 1 | Record valid |
| desc_ready_i | input | 1 | Downstream accepts the record |
| desc_addr_o | output | ADDR_W | Buffer address (bit 31 cleared) |
| desc_len_o | output | LEN_W | Buffer length in bytes |
| desc_last_o | output | 1 | Final record of the walk |

## Verification
Short marked lists show that the walk ends exactly at the flag. This includes the single-entry case, so an off-by-one in the end test would be visible. A marker on the very last permitted entry is compared against a list with no marker at all. This separates a normal end from a limit stop, because both have the same length but must differ in `err_o`. Length and address words with their masked bits forced high show whether those bits leak into the record. Random lists are run under random memory latency and random downstream back-pressure, which exposes any slip in the request order or in how a record is held. Start pulses injected mid-walk and on the done cycle confirm that a running walk cannot be redirected.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned DESC_BYTES = 8;
    localparam int unsigned ADR_WORD_OFS = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEN_REQ,
        ST_LEN_WAIT,
        ST_ADR_REQ,
        ST_ADR_WAIT,
        ST_EMIT,
        ST_DONE
    } walk_st_e;
endpackage

// File: rtl/sgw_word_decode.sv
module sgw_word_decode #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned LEN_W    = 28,
    parameter int unsigned MARK_BIT = 31,
    parameter int unsigned KEEP_W   = 31
) (
    input  logic [sgw_pkg::WORD_W-1:0] len_word_i,
    input  logic [sgw_pkg::WORD_W-1:0] adr_word_i,
    output logic [LEN_W-1:0]           len_o,
    output logic [ADDR_W-1:0]          addr_o,
    output logic                       marker_o
);
    always_comb begin
        len_o    = len_word_i[LEN_W-1:0];
        addr_o   = ADDR_W'(adr_word_i[KEEP_W-1:0]);
        marker_o = len_word_i[MARK_BIT];
    end
endmodule

// File: rtl/sgw_desc_slot.sv
module sgw_desc_slot (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cap_len_i,
    input  logic                       cap_adr_i,
    input  logic [sgw_pkg::WORD_W-1:0] word_i,
    output logic [sgw_pkg::WORD_W-1:0] len_word_o,
    output logic [sgw_pkg::WORD_W-1:0] adr_word_o
);
    typedef struct packed {
        logic [sgw_pkg::WORD_W-1:0] len_word;
        logic [sgw_pkg::WORD_W-1:0] adr_word;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (cap_len_i) slot_d.len_word = word_i;
        if (cap_adr_i) slot_d.adr_word = word_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign len_word_o = slot_q.len_word;
    assign adr_word_o = slot_q.adr_word;
endmodule

// File: rtl/sgw_walk_ctrl.sv
module sgw_walk_ctrl #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned MAX_ENTRIES = 16,
    localparam int unsigned CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              req_ready_i,
    input  logic              rsp_valid_i,
    input  logic              out_ready_i,
    input  logic              rec_marker_i,
    output logic              req_valid_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic              cap_len_o,
    output logic              cap_adr_o,
    output logic              out_valid_o,
    output logic              at_limit_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [CNT_W-1:0]  count_o
);
    import sgw_pkg::*;

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ENTRIES);
    localparam int unsigned      SHIFT = $clog2(DESC_BYTES);

    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  count;
        logic              err;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  final_rec;

    always_comb begin
        final_rec = rec_marker_i || (ctl_q.count + CNT_W'(1) == LIMIT);
        ctl_d     = ctl_q;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st    = ST_LEN_REQ;
                    ctl_d.base  = base_i;
                    ctl_d.count = '0;
                    ctl_d.err   = 1'b0;
                end
            end
            ST_LEN_REQ:  if (req_ready_i) ctl_d.st = ST_LEN_WAIT;
            ST_LEN_WAIT: if (rsp_valid_i) ctl_d.st = ST_ADR_REQ;
            ST_ADR_REQ:  if (req_ready_i) ctl_d.st = ST_ADR_WAIT;
            ST_ADR_WAIT: if (rsp_valid_i) ctl_d.st = ST_EMIT;
            ST_EMIT: begin
                if (out_ready_i) begin
                    ctl_d.count = ctl_q.count + CNT_W'(1);
                    if (final_rec) begin
                        ctl_d.st  = ST_DONE;
                        ctl_d.err = !rec_marker_i;
                    end else begin
                        ctl_d.st = ST_LEN_REQ;
                    end
                end
            end
            ST_DONE: ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, base: '0, count: '0, err: 1'b0};
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        req_valid_o = (ctl_q.st == ST_LEN_REQ) || (ctl_q.st == ST_ADR_REQ);
        req_addr_o  = ctl_q.base + (ADDR_W'(ctl_q.count) << SHIFT)
                    + ((ctl_q.st == ST_ADR_REQ) ? ADDR_W'(ADR_WORD_OFS) : '0);
        cap_len_o   = (ctl_q.st == ST_LEN_WAIT) && rsp_valid_i;
        cap_adr_o   = (ctl_q.st == ST_ADR_WAIT) && rsp_valid_i;
        out_valid_o = (ctl_q.st == ST_EMIT);
        at_limit_o  = (ctl_q.count + CNT_W'(1) == LIMIT);
        busy_o      = (ctl_q.st != ST_IDLE);
        done_o      = (ctl_q.st == ST_DONE);
        err_o       = ctl_q.err;
        count_o     = ctl_q.count;
    end
endmodule

// File: rtl/sg_list_walker.sv
module sg_list_walker #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned LEN_W       = 28,
    parameter int unsigned MAX_ENTRIES = 16,
    localparam int unsigned CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [ADDR_W-1:0]          base_addr_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic                       err_o,
    output logic [CNT_W-1:0]           count_o,
    output logic                       rd_req_valid_o,
    input  logic                       rd_req_ready_i,
    output logic [ADDR_W-1:0]          rd_req_addr_o,
    input  logic                       rd_rsp_valid_i,
    input  logic [sgw_pkg::WORD_W-1:0] rd_rsp_data_i,
    output logic                       desc_valid_o,
    input  logic                       desc_ready_i,
    output logic [ADDR_W-1:0]          desc_addr_o,
    output logic [LEN_W-1:0]           desc_len_o,
    output logic                       desc_last_o
);
    localparam int unsigned MARK_BIT = sgw_pkg::WORD_W - 1;
    localparam int unsigned KEEP_W   = sgw_pkg::WORD_W - 1;

    logic                       cap_len, cap_adr, at_limit, marker;
    logic [sgw_pkg::WORD_W-1:0] len_word, adr_word;

    sgw_walk_ctrl #(.ADDR_W(ADDR_W), .MAX_ENTRIES(MAX_ENTRIES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .base_i       (base_addr_i),
        .req_ready_i  (rd_req_ready_i),
        .rsp_valid_i  (rd_rsp_valid_i),
        .out_ready_i  (desc_ready_i),
        .rec_marker_i (marker),
        .req_valid_o  (rd_req_valid_o),
        .req_addr_o   (rd_req_addr_o),
        .cap_len_o    (cap_len),
        .cap_adr_o    (cap_adr),
        .out_valid_o  (desc_valid_o),
        .at_limit_o   (at_limit),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .count_o      (count_o)
    );

    sgw_desc_slot u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_len_i  (cap_len),
        .cap_adr_i  (cap_adr),
        .word_i     (rd_rsp_data_i),
        .len_word_o (len_word),
        .adr_word_o (adr_word)
    );

    sgw_word_decode #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MARK_BIT(MARK_BIT), .KEEP_W(KEEP_W)
    ) u_dec (
        .len_word_i (len_word),
        .adr_word_i (adr_word),
        .len_o      (desc_len_o),
        .addr_o     (desc_addr_o),
        .marker_o   (marker)
    );

    assign desc_last_o = marker || at_limit;
endmodule

// File: rtl/sgw_chk.sv
module sgw_chk #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned LEN_W       = 28,
    parameter int unsigned MAX_ENTRIES = 16,
    parameter int unsigned CNT_W       = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [CNT_W-1:0]  count_o,
    input logic              rd_req_valid_o,
    input logic              rd_req_ready_i,
    input logic [ADDR_W-1:0] rd_req_addr_o,
    input logic              desc_valid_o,
    input logic              desc_ready_i,
    input logic [ADDR_W-1:0] desc_addr_o,
    input logic [LEN_W-1:0]  desc_len_o,
    input logic              desc_last_o
);
    // R7
    desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(desc_addr_o)
            && $stable(desc_len_o) && $stable(desc_last_o));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_addr_o));

    // R3
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_valid_o && desc_valid_o));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(desc_valid_o && desc_ready_i && desc_last_o));

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(MAX_ENTRIES));

    // R6
    err_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && err_o |-> count_o == CNT_W'(MAX_ENTRIES));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

bind sg_list_walker sgw_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_ENTRIES(MAX_ENTRIES), .CNT_W(CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .err_o          (err_o),
    .count_o        (count_o),
    .rd_req_valid_o (rd_req_valid_o),
    .rd_req_ready_i (rd_req_ready_i),
    .rd_req_addr_o  (rd_req_addr_o),
    .desc_valid_o   (desc_valid_o),
    .desc_ready_i   (desc_ready_i),
    .desc_addr_o    (desc_addr_o),
    .desc_len_o     (desc_len_o),
    .desc_last_o    (desc_last_o)
);

// File: tb/sg_list_walker_tb.sv
module sg_list_walker_tb;
    localparam int MAXE  = 16;
    localparam int CNT_W = $clog2(MAXE + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [31:0]      base_addr_i = '0;
    logic             busy_o, done_o, err_o;
    logic [CNT_W-1:0] count_o;
    logic             rd_req_valid_o, rd_req_ready_i = 1'b0;
    logic [31:0]      rd_req_addr_o;
    logic             rd_rsp_valid_i = 1'b0;
    logic [31:0]      rd_rsp_data_i = '0;
    logic             desc_valid_o, desc_ready_i = 1'b0;
    logic [31:0]      desc_addr_o;
    logic [27:0]      desc_len_o;
    logic             desc_last_o;

    always #10 clk = ~clk;

    sg_list_walker #(.MAX_ENTRIES(MAXE)) u_dut (.*);

    int checks = 0, fails = 0;
    logic [31:0] mem [int unsigned];
    logic [31:0] exp_addr [MAXE];
    logic [27:0] exp_len  [MAXE];
    bit          exp_last [MAXE];
    int          rec_idx = 0, req_n = 0;
    logic [31:0] walk_base = '0;
    int          req_pct = 100, rdy_pct = 100;
    bit          finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory responder: one request outstanding, latency 0..2 cycles after accept
    initial begin
        bit pend = 0;
        int dly = 0;
        logic [31:0] paddr = '0;
        forever begin
            @(negedge clk);
            rd_rsp_valid_i = 1'b0;
            if (pend) begin
                rd_req_ready_i = 1'b0;
                if (dly == 0) begin
                    rd_rsp_valid_i = 1'b1;
                    rd_rsp_data_i  = rd_mem(paddr);
                    pend = 0;
                end else dly--;
            end else if (rd_req_valid_o && ($urandom % 100) < req_pct) begin
                rd_req_ready_i = 1'b1;
                // R3: length word then address word of each descriptor
                chk(rd_req_addr_o == walk_base + 32'(8 * (req_n / 2) + 4 * (req_n % 2)),
                    "R3 request address", rd_req_addr_o,
                    walk_base + 32'(8 * (req_n / 2) + 4 * (req_n % 2)));
                req_n++;
                pend  = 1;
                paddr = rd_req_addr_o;
                dly   = $urandom % 3;
            end else rd_req_ready_i = 1'b0;
        end
    end

    // downstream sink with record comparison
    initial begin
        forever begin
            @(negedge clk);
            desc_ready_i = (($urandom % 100) < rdy_pct);
            if (desc_valid_o && desc_ready_i) begin
                if (rec_idx >= MAXE) begin
                    chk(0, "R5 record beyond list end", rec_idx, MAXE - 1);
                end else begin
                    chk(desc_addr_o == exp_addr[rec_idx], "R4 record address",
                        desc_addr_o, exp_addr[rec_idx]);
                    chk(desc_len_o == exp_len[rec_idx], "R4 record length",
                        desc_len_o, exp_len[rec_idx]);
                    chk(desc_last_o == exp_last[rec_idx], "R5/R6 record last flag",
                        desc_last_o, exp_last[rec_idx]);
                end
                rec_idx++;
            end
        end
    end

    // build a list; nomark writes MAXE entries without the end flag
    task automatic fill_list(input logic [31:0] base, input int n, input bit nomark,
                             input bit junk);
        int ents = nomark ? MAXE : n;
        for (int i = 0; i < ents; i++) begin
            logic [31:0] lw = $urandom;
            logic [31:0] aw = $urandom;
            if (junk) begin
                lw[30:28] = 3'b111;
                aw[31] = 1'b1;
            end
            lw[31] = !nomark && (i == n - 1);
            mem[base + 32'(8 * i)]     = lw;
            mem[base + 32'(8 * i + 4)] = aw;
            exp_len[i]  = lw[27:0];
            exp_addr[i] = {1'b0, aw[30:0]};
            exp_last[i] = lw[31] || (i == MAXE - 1);
        end
    endtask

    task automatic run_walk(input logic [31:0] base, input int n_exp, input bit err_exp,
                            input bit mid_start, input bit done_start);
        int k = 0;
        walk_base = base;
        req_n = 0;
        rec_idx = 0;
        @(negedge clk);
        start_i = 1'b1;
        base_addr_i = base;
        @(negedge clk);
        start_i = 1'b0;
        // R2
        chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        chk(rd_req_valid_o && rd_req_addr_o == base, "R2 first request at base",
            rd_req_addr_o, base);
        while (!done_o && k < 4000) begin
            @(negedge clk);
            k++;
            if (mid_start && k == 5) begin
                start_i = 1'b1;
                base_addr_i = base + 32'h400;
            end
            if (mid_start && k == 6) start_i = 1'b0;
        end
        start_i = 1'b0;
        if (!done_o) begin
            chk(0, "R8 walk never finished", 0, 1);
            return;
        end
        chk(count_o == CNT_W'(n_exp), "R8 count at done", count_o, n_exp);
        chk(rec_idx == n_exp, "R5 records delivered", rec_idx, n_exp);
        chk(err_o == err_exp, "R6 error flag", err_o, err_exp);
        if (done_start) begin
            start_i = 1'b1;
            base_addr_i = base + 32'h800;
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R8 done is one cycle", done_o, 0);
        chk(count_o == CNT_W'(n_exp) && err_o == err_exp, "R8 results held",
            count_o, n_exp);
        if (done_start) begin
            chk(busy_o == 1'b0 && rd_req_valid_o == 1'b0, "R9 start on done cycle ignored",
                busy_o, 0);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R1
        chk(!busy_o && !done_o && !err_o && count_o == '0, "R1 reset state", busy_o, 0);
        chk(!rd_req_valid_o && !desc_valid_o, "R1 no valid in reset", rd_req_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !rd_req_valid_o && !desc_valid_o, "R1 idle after reset", busy_o, 0);

        // single entry, masked bits forced high (R4, R5)
        fill_list(32'h0000_0100, 1, 0, 1);
        run_walk(32'h0000_0100, 1, 0, 0, 0);
        // marker on the very last permitted entry (R6: no error)
        fill_list(32'h0000_1000, MAXE, 0, 1);
        run_walk(32'h0000_1000, MAXE, 0, 0, 1);
        // no marker at all (R6: limit stop with error)
        fill_list(32'h0000_2000, 0, 1, 0);
        run_walk(32'h0000_2000, MAXE, 1, 0, 0);
        // heavy back-pressure on both sides (R3, R7)
        req_pct = 30;
        rdy_pct = 20;
        fill_list(32'h0000_3000, 6, 0, 0);
        run_walk(32'h0000_3000, 6, 0, 0, 0);
        // start while busy (R9)
        req_pct = 100;
        rdy_pct = 100;
        fill_list(32'h0000_3400, 3, 0, 0);
        fill_list(32'h0000_3000, 10, 0, 0);
        run_walk(32'h0000_3000, 10, 0, 1, 1);
        // random lists
        for (int t = 0; t < 30; t++) begin
            logic [31:0] b = {12'h0, 4'(t), 8'($urandom), 8'h0};
            bit nm = (($urandom % 10) == 0);
            int n = 1 + int'($urandom % MAXE);
            req_pct = 40 + int'($urandom % 61);
            rdy_pct = 40 + int'($urandom % 61);
            fill_list(b, n, nm, 0);
            run_walk(b, nm ? MAXE : n, nm, ($urandom % 4) == 0 && n > 4, ($urandom % 2) == 0);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule